// File: doc/BRIEF.md
# Keyboard Serial Receive Controller

This block takes in the frames a keyboard sends on a two-wire open-drain link. The keyboard drives both wires: a clock line and a data line. The block passes both lines through a synchronizer and finds the falling edges of the keyboard clock in the system clock domain. On each of those edges it takes one bit from the data line. An 11-bit frame is a zero start bit, then eight data bits with the least significant bit first, then an odd parity bit, then a one stop bit. The block checks the parity and the start and stop bits of each frame. A good frame goes into a byte buffer.

Once a good frame is in the buffer, the block pulls the keyboard clock line low. While the line is low the keyboard cannot start another frame. The line stays low until software reads the byte and writes zero to the buffer-full flag. Software uses a small register port to set up the block and to read it:
- a control/status byte with a receive enable, a link enable, an interrupt enable, the buffer-full, parity-error and framing-error flags, and the present levels of both lines;
- the received byte.

A watchdog counter clears a frame that stops partway through. A level interrupt output follows the buffer-full flag when interrupts are enabled.

Top module: `kbd_rx_ctrl`

## Requirements
- R1: A frame is 11 bits in this order: start, data bit 0 to data bit 7 (LSB first), parity, stop. After a good frame, register address 1 reads the received byte.
- R2: Each bit is taken on a falling edge of the synchronized keyboard clock. Changes on the data line while the clock is high have no effect.
- R3: A good frame (start 0, stop 1) sets buffer-full (control bit 3). It also asserts the clock drive-low output `kb_clk_pull_low` one cycle after the frame completes.
- R4: The `irq` output is 1 exactly when buffer-full and interrupt enable (control bit 2) are both 1.
- R5: A write to address 0 with bit 3 equal to 0 clears buffer-full and parity-error and releases the clock line on the next cycle. A write with bit 3 equal to 1 leaves buffer-full as it is.
- R6: Control bit 4 (parity error) is set with buffer-full when the eight data bits and the parity bit together hold an even number of ones. The byte is stored in either case.
- R7: Control bit 6 reads the synchronized clock line and bit 7 reads the synchronized data line.
- R8: Frames are received only while receive enable (bit 0) and link enable (bit 1) are both 1. Otherwise the bit counter is held at 0 and a frame leaves every flag and the buffer unchanged.
- R9: A partial frame is discarded when no keyboard clock fall arrives for TIMEOUT_CYC system cycles. The next full frame is then received correctly.
- R10: A start bit of 1 or a stop bit of 0 sets framing error (bit 5) and neither sets buffer-full nor holds the clock. Writing 0 to bit 5 clears the framing error and writing 1 keeps it.
- R11: While buffer-full is set, further keyboard clock activity does not change the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk_in | input | 1 | Level seen on the keyboard clock line |
| kb_dat_in | input | 1 | Level seen on the keyboard data line |
| kb_clk_pull_low | output | 1 | Drive-low enable for the open-drain clock line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control/status, 1 data) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Receive interrupt request (level) |

## Verification
The bench drives frames whose parity is flipped on purpose or whose start or stop bit is wrong.
- If the design mixed up the parity sense, a clean byte would come out flagged as an error.
- If it did not check the start or stop bit, a bad frame would set buffer-full and freeze the link.

The bench also cuts a frame off partway and waits past the timeout before sending a full frame. Without the watchdog, the stale bit count would shift that next frame out of line and report a framing error.

Other cases the bench covers:
- Each enable is turned off in turn, to show that one enable alone receives nothing.
- A second frame is pushed while the buffer is full, to show that the stored byte does not change.
- Both write polarities of the two clearable flags are checked, to show that a write of 1 neither clears nor sets a flag.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 3;

  // control/status bit positions
  localparam int CB_RX_EN   = 0;
  localparam int CB_LINK_EN = 1;
  localparam int CB_IRQ_EN  = 2;
  localparam int CB_FULL    = 3;
  localparam int CB_PERR    = 4;
  localparam int CB_FERR    = 5;
  localparam int CB_CLK_LVL = 6;
  localparam int CB_DAT_LVL = 7;

  // odd parity: data plus parity bit must hold an odd count of ones
  function automatic logic parity_is_odd(input logic [DATA_BITS-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  function automatic logic frame_edges_ok(input logic start_b, input logic stop_b);
    return (start_b == 1'b0) && (stop_b == 1'b1);
  endfunction
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  output logic [LINES-1:0] line_sync,
  output logic [LINES-1:0] line_fall
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '1;
          prev  <= 1'b1;
        end else begin
          chain <= {chain[STAGES-2:0], line_in[g]};
          prev  <= chain[STAGES-1];
        end
      end
      assign line_sync[g] = chain[STAGES-1];
      assign line_fall[g] = prev & ~chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_rx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 40000,
  localparam int CNT_W = $clog2(FRAME_BITS),
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic                 fall,
  input  logic                 din,
  output logic                 frame_ok,
  output logic                 frame_bad,
  output logic                 timed_out,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 par_err_o,
  output logic [CNT_W-1:0]     bit_cnt_o
);
  localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] POS_PAR  = CNT_W'(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] POS_D7   = CNT_W'(DATA_BITS);
  localparam logic [TMO_W-1:0] TMO_END  = TMO_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0]     cnt;
  logic [DATA_BITS-1:0] shreg;
  logic                 start_q;
  logic                 par_q;
  logic [TMO_W-1:0]     tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      shreg     <= '0;
      start_q   <= 1'b0;
      par_q     <= 1'b0;
      tmo       <= '0;
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
      timed_out <= 1'b0;
      if (!active) begin
        cnt <= '0;
        tmo <= '0;
      end else if (fall) begin
        tmo <= '0;
        if (cnt == '0)
          start_q <= din;
        else if (cnt <= POS_D7)
          shreg <= {din, shreg[DATA_BITS-1:1]};
        else if (cnt == POS_PAR)
          par_q <= din;
        if (cnt == POS_LAST) begin
          cnt <= '0;
          if (frame_edges_ok(start_q, din)) frame_ok  <= 1'b1;
          else                              frame_bad <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (cnt != '0) begin
        if (tmo == TMO_END) begin
          cnt       <= '0;
          tmo       <= '0;
          timed_out <= 1'b1;
        end else begin
          tmo <= tmo + 1'b1;
        end
      end
    end
  end

  assign data_o    = shreg;
  assign par_err_o = ~parity_is_odd(shreg, par_q);
  assign bit_cnt_o = cnt;
endmodule

// File: rtl/kbd_rx_ctrl.sv
module kbd_rx_ctrl
  import kbd_rx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 40000,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_clk_in,
  input  logic              kb_dat_in,
  output logic              kb_clk_pull_low,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(1);

  logic [1:0] lsync, lfall;
  logic       clk_s, dat_s, clk_fall;

  kbd_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .line_in({kb_dat_in, kb_clk_in}),
    .line_sync(lsync), .line_fall(lfall)
  );
  assign clk_s    = lsync[0];
  assign dat_s    = lsync[1];
  assign clk_fall = lfall[0];

  logic rx_en, link_en, irq_en, full, perr, ferr;
  logic [DATA_BITS-1:0] rx_buf;
  logic active;
  logic frame_ok, frame_bad, timed_out, par_err_c;
  logic [DATA_BITS-1:0] rx_byte;
  logic [CNT_W-1:0] bit_cnt;
  logic ctrl_wr, clr_full, clr_ferr;

  assign active = rx_en & link_en & ~full;

  kbd_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
    .clk(clk), .rst_n(rst_n), .active(active), .fall(clk_fall), .din(dat_s),
    .frame_ok(frame_ok), .frame_bad(frame_bad), .timed_out(timed_out),
    .data_o(rx_byte), .par_err_o(par_err_c), .bit_cnt_o(bit_cnt)
  );

  assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  assign clr_full = ctrl_wr && !reg_wdata[CB_FULL];
  assign clr_ferr = ctrl_wr && !reg_wdata[CB_FERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en   <= 1'b0;
      link_en <= 1'b0;
      irq_en  <= 1'b0;
      full    <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      rx_buf  <= '0;
    end else begin
      if (ctrl_wr) begin
        rx_en   <= reg_wdata[CB_RX_EN];
        link_en <= reg_wdata[CB_LINK_EN];
        irq_en  <= reg_wdata[CB_IRQ_EN];
      end
      if (frame_ok) begin
        full   <= 1'b1;
        perr   <= par_err_c;
        rx_buf <= rx_byte;
      end else if (clr_full) begin
        full <= 1'b0;
        perr <= 1'b0;
      end
      if (frame_bad)     ferr <= 1'b1;
      else if (clr_ferr) ferr <= 1'b0;
    end
  end

  assign kb_clk_pull_low = full;
  assign irq             = full & irq_en;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[CB_RX_EN]   = rx_en;
      reg_rdata[CB_LINK_EN] = link_en;
      reg_rdata[CB_IRQ_EN]  = irq_en;
      reg_rdata[CB_FULL]    = full;
      reg_rdata[CB_PERR]    = perr;
      reg_rdata[CB_FERR]    = ferr;
      reg_rdata[CB_CLK_LVL] = clk_s;
      reg_rdata[CB_DAT_LVL] = dat_s;
    end else if (reg_addr == A_DATA) begin
      reg_rdata = rx_buf;
    end
  end
endmodule

// File: rtl/kbd_rx_chk.sv
module kbd_rx_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_ok,
  input logic             frame_bad,
  input logic             timed_out,
  input logic             full,
  input logic             ferr,
  input logic             irq,
  input logic             active,
  input logic             clr_full,
  input logic             kb_clk_pull_low,
  input logic [CNT_W-1:0] bit_cnt
);
  assert_hold_after_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> full && kb_clk_pull_low);

  assert_irq_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> full);

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_full && !frame_ok) |=> !full && !kb_clk_pull_low);

  assert_idle_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> bit_cnt == '0);

  assert_timeout_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> bit_cnt == '0);

  assert_bad_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> ferr && !full);

  assert_full_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !active);

  assert_frame_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_bad));
endmodule

bind kbd_rx_ctrl kbd_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_bad(frame_bad),
  .timed_out(timed_out), .full(full), .ferr(ferr), .irq(irq), .active(active),
  .clr_full(clr_full), .kb_clk_pull_low(kb_clk_pull_low), .bit_cnt(bit_cnt)
);

// File: tb/kbd_rx_ctrl_bench.sv
module kbd_rx_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 300;
  localparam int HP         = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kbd_clk_low = 1'b0, kbd_dat_low = 1'b0;
  logic pull_low;
  wire  clk_line = !(kbd_clk_low | pull_low);
  wire  dat_line = !kbd_dat_low;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_rx_ctrl #(.TIMEOUT_CYC(TMO)) u_kbd_rx_ctrl (
    .clk(clk), .rst_n(rst_n), .kb_clk_in(clk_line), .kb_dat_in(dat_line),
    .kb_clk_pull_low(pull_low), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [7:0] b;
    logic       flip_par;
    logic       bad_start;
    logic       bad_stop;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hA5, 1'b0, 1'b0, 1'b0},
    '{8'h01, 1'b0, 1'b0, 1'b0},
    '{8'h80, 1'b1, 1'b0, 1'b0},
    '{8'hFF, 1'b0, 1'b0, 1'b0},
    '{8'h5A, 1'b0, 1'b1, 1'b0},
    '{8'h33, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // keyboard model: data changes mid-high, clock low for HP cycles
  task automatic send_frame(input logic [7:0] b, input logic fp, input logic bs,
                            input logic bt, input int nbits, input bit wait_idle);
    logic [10:0] f;
    f[0] = bs;
    f[8:1] = b;
    f[9] = (~^b) ^ fp;
    f[10] = ~bt;
    if (wait_idle) while (!clk_line) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      wait_cyc(HP/4);
      kbd_dat_low = !f[i];
      wait_cyc(HP/4);
      kbd_clk_low = 1'b1;
      wait_cyc(HP);
      kbd_clk_low = 1'b0;
      wait_cyc(HP/4);
      kbd_dat_low = 1'b0;   // glitch data while high (R2)
      wait_cyc(HP/4);
    end
    kbd_dat_low = 1'b0;
    wait_cyc(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic ok;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // reset state
    rd_reg(2'd0, r);
    check("R7 reset ctrl", r, 8'hC0);
    check("R3 reset pull", pull_low, 0);
    check("R4 reset irq", irq, 0);

    // table walk
    foreach (VECS[k]) begin
      wr_reg(2'd0, 8'h07);
      send_frame(VECS[k].b, VECS[k].flip_par, VECS[k].bad_start, VECS[k].bad_stop, 11, 1);
      ok = !VECS[k].bad_start && !VECS[k].bad_stop;
      rd_reg(2'd0, r);
      check("R3/R6/R10 flags", r & 8'h3F,
            {2'b00, !ok, ok & VECS[k].flip_par, ok, 3'b111});
      check("R7 clk level", r[6], !ok);
      check("R3 pull low", pull_low, ok);
      check("R4 irq", irq, ok);
      if (ok) begin
        rd_reg(2'd1, r);
        check("R1 R2 byte", r, VECS[k].b);
      end
      wr_reg(2'd0, 8'h0F);   // bit3=1 keeps full (R5)
      check("R5 keep full", pull_low, ok);
      wr_reg(2'd0, 8'h07);
      check("R5 release", pull_low, 0);
      rd_reg(2'd0, r);
      check("R5 R10 cleared", r & 8'h38, 0);
    end

    // R10: writing 1 to bit5 keeps framing error
    wr_reg(2'd0, 8'h07);
    send_frame(8'h12, 0, 1, 0, 11, 1);
    wr_reg(2'd0, 8'h27);
    rd_reg(2'd0, r);
    check("R10 ferr kept", r[5], 1);
    wr_reg(2'd0, 8'h07);
    rd_reg(2'd0, r);
    check("R10 ferr cleared", r[5], 0);

    // R8: link enable off, then receive enable off
    wr_reg(2'd0, 8'h01);
    send_frame(8'h44, 0, 0, 0, 11, 1);
    rd_reg(2'd0, r);
    check("R8 link off", r & 8'h38, 0);
    check("R8 link off pull", pull_low, 0);
    wr_reg(2'd0, 8'h02);
    send_frame(8'h44, 0, 0, 0, 11, 1);
    rd_reg(2'd0, r);
    check("R8 rx off", r & 8'h38, 0);

    // R4: interrupt disabled
    wr_reg(2'd0, 8'h03);
    send_frame(8'h6E, 0, 0, 0, 11, 1);
    rd_reg(2'd0, r);
    check("R4 full w/o irq_en", r[3], 1);
    check("R4 irq off", irq, 0);

    // R11: keyboard pushes another frame while buffer full
    send_frame(8'h91, 0, 0, 0, 11, 0);
    rd_reg(2'd1, r);
    check("R11 buffer kept", r, 8'h6E);
    wr_reg(2'd0, 8'h07);

    // R9: partial frame then timeout
    send_frame(8'hFF, 0, 0, 0, 4, 1);
    wait_cyc(TMO + 50);
    send_frame(8'hC3, 0, 0, 0, 11, 1);
    rd_reg(2'd0, r);
    check("R9 no ferr", r[5], 0);
    check("R9 full", r[3], 1);
    rd_reg(2'd1, r);
    check("R9 byte", r, 8'hC3);
    wr_reg(2'd0, 8'h07);

    // R7: data line level readback
    kbd_dat_low = 1'b1;
    wait_cyc(5);
    rd_reg(2'd0, r);
    check("R7 dat low", r[7:6], 2'b01);
    kbd_dat_low = 1'b0;
    wait_cyc(5);
    rd_reg(2'd0, r);
    check("R7 dat high", r[7:6], 2'b11);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule